// File: doc/BRIEF.md
# I2C Controller Register and Status Bank

This block is the register front end of a byte-level I2C controller. Host software reaches it through a small byte-wide access port: one read or one write per cycle, a 3-bit offset, and write data that is 16 bits wide so the clock register can be loaded in one access. The block holds the data byte, the sticky status flags, the match and busy indications, two control registers, the own-address register and the clock/enable register. It drives the request and policy outputs used by a separate bit-level bus engine, and it raises a level interrupt.

The bus engine reports what happens on the wire through one-cycle event pulses, such as a received byte, a request for a byte to send, a bus error, a NACK, a completed start or an address match. The block turns these pulses into sticky flags. Most flags are cleared by writing a 1 to their status bit. The data-ready flag is different: software clears it by reading or writing the data register. An optional stall flag tells the engine to hold the bus after a start condition until software clears that flag. When the enable bit in the clock register is cleared, all flags and pending requests are reset, which gives software a soft reset by writing enable 0 and then enable 1.

Top module: `i2c_regbank`

## Requirements
- R1: After reset every register reads zero, every status flag is clear, and irq, start_req, stop_req, tx_load and ctl_en are low.
- R2: The registers sit at these offsets: data 0, status 1, control/status 2, control1 3, own address 4, clock/enable 5 (16-bit), control3 6. Control1 reads back bits 7:4 and 2 as written, bit 3 always reads 0, and bits 1:0 read the pending stop and start requests. Control3 and the own-address register read back as written. Offset 7 reads zero.
- R3: Status bits, MSB first: bit 7 slave stop, bit 6 data ready, bit 5 bus error, bit 4 NACK, bit 3 stall after start, bit 2 new address match, bit 1 engine master level, bit 0 engine transmit level. Writing 1 to bit 7, 5, 4, 3 or 2 clears that flag. Writing 0 to a bit has no effect.
- R4: Data ready is set by ev_tx_empty or ev_rx_valid. Writing 1 to status bit 6 does not clear it. A read or write of offset 0 clears it.
- R5: When an event that sets a flag arrives in the same cycle as a clear of that flag (a status write-1 or a data access), the flag ends up set.
- R6: ev_start_done sets the stall flag only while control1 bit 7 (stall enable) is 1. stall_hold is high exactly while the stall flag and stall enable are both set.
- R7: Writing 1 to control1 bit 0 (bit 1) raises start_req (stop_req). Writing 0 to either bit leaves the request unchanged. start_ack (stop_ack) clears the matching request.
- R8: The control/status register reads bit 3 general-call match, bit 2 own-address match, bit 1 bus busy (eng_bus_busy) and bit 0 controller busy (eng_ctl_busy). ev_own_match and ev_gcall_match also set the new-match status flag. A new match replaces the previous match kind. ev_slave_stop clears both match bits.
- R9: irq is high when control1 bit 2 is 1 and any of status bits 7..2 is set. The master and transmit bits never raise irq.
- R10: Clock/enable bit 0 is ctl_en and bits 15:1 are scl_div; for example, 0x258, 0x078 and 0x03C give about 10, 50 and 100 kHz. While ctl_en is 0, all flags, match bits and requests read zero and engine events are ignored. A write with bit 0 clear resets them in that same cycle.
- R11: A write to offset 0 loads tx_data and, if enabled, pulses tx_load for one cycle. ev_rx_valid loads rx_byte into the data register, where it can be read at offset 0.
- R12: nack_next, match_irq_en and gcall_en follow control1 bits 4, 6 and 5. slave_en follows own-address bit 7, and own_addr follows bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 3 | Register offset |
| acc_wdata | input | 16 | Write data (low byte except offset 5) |
| acc_rdata | output | 16 | Read data for acc_addr |
| ev_slave_stop | input | 1 | Stop seen while addressed as slave |
| ev_bus_err | input | 1 | Bus error seen |
| ev_nack | input | 1 | NACK received |
| ev_start_done | input | 1 | Start condition completed |
| ev_own_match | input | 1 | Own address matched |
| ev_gcall_match | input | 1 | General call matched |
| ev_tx_empty | input | 1 | Engine needs a byte to send |
| ev_rx_valid | input | 1 | Engine received a byte |
| rx_byte | input | 8 | Received byte |
| eng_master | input | 1 | Engine is bus master |
| eng_xmit | input | 1 | Engine is transmitting |
| eng_bus_busy | input | 1 | Bus is busy |
| eng_ctl_busy | input | 1 | Controller is busy |
| start_ack | input | 1 | Engine accepted start request |
| stop_ack | input | 1 | Engine accepted stop request |
| ctl_en | output | 1 | Controller enable |
| scl_div | output | 15 | SCL divisor |
| start_req | output | 1 | Pending start request |
| stop_req | output | 1 | Pending stop request |
| nack_next | output | 1 | NACK the next received byte |
| stall_en | output | 1 | Stall after start enabled |
| stall_hold | output | 1 | Engine must hold the bus |
| match_irq_en | output | 1 | New-match interrupt enable |
| gcall_en | output | 1 | General-call response enable |
| slave_en | output | 1 | Slave address enable |
| own_addr | output | 7 | Own slave address |
| tx_data | output | 8 | Byte to transmit |
| tx_load | output | 1 | One-cycle pulse: new byte written |
| irq | output | 1 | Level interrupt |

## Verification
The function most exposed to collisions is flag clearing. A bus event can arrive in the same cycle that software clears the same flag, either by a write-1 to the status register or by a data-register access. The bench drives the event and the access on the same falling edge and then reads the status register one cycle later, where a lost event shows up as a cleared bit. The same approach covers a request acknowledge that coincides with a new request write.

// File: rtl/i2c_regbank.sv
module i2c_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [2:0]  acc_addr,
  input  logic [15:0] acc_wdata,
  output logic [15:0] acc_rdata,
  input  logic        ev_slave_stop,
  input  logic        ev_bus_err,
  input  logic        ev_nack,
  input  logic        ev_start_done,
  input  logic        ev_own_match,
  input  logic        ev_gcall_match,
  input  logic        ev_tx_empty,
  input  logic        ev_rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        eng_master,
  input  logic        eng_xmit,
  input  logic        eng_bus_busy,
  input  logic        eng_ctl_busy,
  input  logic        start_ack,
  input  logic        stop_ack,
  output logic        ctl_en,
  output logic [14:0] scl_div,
  output logic        start_req,
  output logic        stop_req,
  output logic        nack_next,
  output logic        stall_en,
  output logic        stall_hold,
  output logic        match_irq_en,
  output logic        gcall_en,
  output logic        slave_en,
  output logic [6:0]  own_addr,
  output logic [7:0]  tx_data,
  output logic        tx_load,
  output logic        irq
);

  logic [7:0]  data_q;
  logic [3:0]  c1_hi;
  logic        c1_ien;
  logic [7:0]  oa_q;
  logic [15:0] c2_q;
  logic [7:0]  c3_q;

  logic f_slvstp, f_sdast, f_ber, f_nack, f_stall, f_nmatch;
  logic m_own, m_gc;

  logic wr_data, wr_sts, wr_c1, wr_oa, wr_c2, wr_c3, data_acc, go_off;
  logic [5:0] flags;

  assign wr_data  = acc_wr && acc_addr == 3'd0;
  assign wr_sts   = acc_wr && acc_addr == 3'd1;
  assign wr_c1    = acc_wr && acc_addr == 3'd3;
  assign wr_oa    = acc_wr && acc_addr == 3'd4;
  assign wr_c2    = acc_wr && acc_addr == 3'd5;
  assign wr_c3    = acc_wr && acc_addr == 3'd6;
  assign data_acc = (acc_wr || acc_rd) && acc_addr == 3'd0;
  assign go_off   = !ctl_en || (wr_c2 && !acc_wdata[0]);

  assign ctl_en       = c2_q[0];
  assign scl_div      = c2_q[15:1];
  assign stall_en     = c1_hi[3];
  assign match_irq_en = c1_hi[2];
  assign gcall_en     = c1_hi[1];
  assign nack_next    = c1_hi[0];
  assign slave_en     = oa_q[7];
  assign own_addr     = oa_q[6:0];
  assign tx_data      = data_q;
  assign stall_hold   = f_stall && stall_en;

  assign flags = {f_slvstp, f_sdast, f_ber, f_nack, f_stall, f_nmatch};
  assign irq   = c1_ien && (|flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_hi  <= '0;
      c1_ien <= 1'b0;
      oa_q   <= '0;
      c2_q   <= '0;
      c3_q   <= '0;
    end else begin
      if (wr_c1) begin
        c1_hi  <= acc_wdata[7:4];
        c1_ien <= acc_wdata[2];
      end
      if (wr_oa) oa_q <= acc_wdata[7:0];
      if (wr_c2) c2_q <= acc_wdata;
      if (wr_c3) c3_q <= acc_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= wr_data && ctl_en;
      if (ev_rx_valid && ctl_en) data_q <= rx_byte;
      else if (wr_data)          data_q <= acc_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_slvstp  <= 1'b0;
      f_sdast   <= 1'b0;
      f_ber     <= 1'b0;
      f_nack    <= 1'b0;
      f_stall   <= 1'b0;
      f_nmatch  <= 1'b0;
      m_own     <= 1'b0;
      m_gc      <= 1'b0;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
    end else if (go_off) begin
      f_slvstp  <= 1'b0;
      f_sdast   <= 1'b0;
      f_ber     <= 1'b0;
      f_nack    <= 1'b0;
      f_stall   <= 1'b0;
      f_nmatch  <= 1'b0;
      m_own     <= 1'b0;
      m_gc      <= 1'b0;
      start_req <= 1'b0;
      stop_req  <= 1'b0;
    end else begin
      f_slvstp  <= ev_slave_stop | (f_slvstp & ~(wr_sts & acc_wdata[7]));
      f_sdast   <= ev_tx_empty | ev_rx_valid | (f_sdast & ~data_acc);
      f_ber     <= ev_bus_err | (f_ber & ~(wr_sts & acc_wdata[5]));
      f_nack    <= ev_nack | (f_nack & ~(wr_sts & acc_wdata[4]));
      f_stall   <= (ev_start_done & stall_en) | (f_stall & ~(wr_sts & acc_wdata[3]));
      f_nmatch  <= ev_own_match | ev_gcall_match | (f_nmatch & ~(wr_sts & acc_wdata[2]));
      if (ev_own_match) begin
        m_own <= 1'b1;
        m_gc  <= 1'b0;
      end else if (ev_gcall_match) begin
        m_own <= 1'b0;
        m_gc  <= 1'b1;
      end else if (ev_slave_stop) begin
        m_own <= 1'b0;
        m_gc  <= 1'b0;
      end
      start_req <= (wr_c1 & acc_wdata[0]) | (start_req & ~start_ack);
      stop_req  <= (wr_c1 & acc_wdata[1]) | (stop_req & ~stop_ack);
    end
  end

  always_comb begin
    case (acc_addr)
      3'd0:    acc_rdata = {8'h00, data_q};
      3'd1:    acc_rdata = {8'h00, flags, eng_master, eng_xmit};
      3'd2:    acc_rdata = {12'h000, m_gc, m_own, eng_bus_busy, eng_ctl_busy};
      3'd3:    acc_rdata = {8'h00, c1_hi, 1'b0, c1_ien, stop_req, start_req};
      3'd4:    acc_rdata = {8'h00, oa_q};
      3'd5:    acc_rdata = c2_q;
      3'd6:    acc_rdata = {8'h00, c3_q};
      default: acc_rdata = 16'h0000;
    endcase
  end

endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_wr,
  input logic       acc_rd,
  input logic [2:0] acc_addr,
  input logic       wd0,
  input logic       ctl_en,
  input logic [5:0] flags,
  input logic       sdast,
  input logic       ien,
  input logic       start_req,
  input logic       start_ack,
  input logic       stop_req,
  input logic       stall_en,
  input logic       stall_hold,
  input logic       tx_load,
  input logic       irq
);

  logic off_wr;
  assign off_wr = acc_wr && acc_addr == 3'd5 && !wd0;

  a_r4_sdast_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && sdast && !((acc_wr || acc_rd) && acc_addr == 3'd0) && !off_wr) |=> sdast);

  a_r7_start_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && start_ack && !(acc_wr && acc_addr == 3'd3 && wd0)) |=> !start_req);

  a_r7_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !start_ack && ctl_en && !off_wr) |=> start_req);

  a_r10_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (flags == 6'd0 && !start_req && !stop_req));

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  a_r6_hold_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hold |-> stall_en);

  a_r11_load_src: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(acc_wr && acc_addr == 3'd0 && ctl_en));

endmodule

bind i2c_regbank i2c_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_wr     (acc_wr),
  .acc_rd     (acc_rd),
  .acc_addr   (acc_addr),
  .wd0        (acc_wdata[0]),
  .ctl_en     (ctl_en),
  .flags      (flags),
  .sdast      (f_sdast),
  .ien        (c1_ien),
  .start_req  (start_req),
  .start_ack  (start_ack),
  .stop_req   (stop_req),
  .stall_en   (stall_en),
  .stall_hold (stall_hold),
  .tx_load    (tx_load),
  .irq        (irq)
);

// File: tb/tb_i2c_regbank.sv
module tb_i2c_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_wr = 0, acc_rd = 0;
  logic [2:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic [15:0] acc_rdata;
  logic ev_slave_stop = 0, ev_bus_err = 0, ev_nack = 0, ev_start_done = 0;
  logic ev_own_match = 0, ev_gcall_match = 0, ev_tx_empty = 0, ev_rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic eng_master = 0, eng_xmit = 0, eng_bus_busy = 0, eng_ctl_busy = 0;
  logic start_ack = 0, stop_ack = 0;
  logic ctl_en, start_req, stop_req, nack_next, stall_en, stall_hold;
  logic match_irq_en, gcall_en, slave_en, tx_load, irq;
  logic [14:0] scl_div;
  logic [6:0] own_addr;
  logic [7:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regbank dut (.*);

  task automatic tick();
    @(negedge clk);
    acc_wr = 0; acc_rd = 0;
    ev_slave_stop = 0; ev_bus_err = 0; ev_nack = 0; ev_start_done = 0;
    ev_own_match = 0; ev_gcall_match = 0; ev_tx_empty = 0; ev_rx_valid = 0;
    start_ack = 0; stop_ack = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    acc_wr = 1; acc_addr = a; acc_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    acc_rd = 1; acc_addr = a;
    #1 d = acc_rdata;
    tick();
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_flags();
    wr(3'd1, 16'h00FF);
    rd(3'd0, rv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], rv);
      chk("R1 reg after reset", rv, 16'h0000);
    end
    chk("R1 outputs after reset", {11'd0, irq, start_req, stop_req, tx_load, ctl_en}, 16'h0000);

    // R10 events ignored while disabled
    ev_bus_err = 1; ev_tx_empty = 1; ev_own_match = 1; tick();
    wr(3'd3, 16'h0001);
    rd(3'd1, rv); chk("R10 status while disabled", rv, 16'h0000);
    chk("R10 start ignored while disabled", {15'd0, start_req}, 16'h0000);

    // R10 divisor sweep
    begin
      logic [14:0] divs [3];
      divs[0] = 15'h258; divs[1] = 15'h078; divs[2] = 15'h03C;
      for (int i = 0; i < 3; i++) begin
        wr(3'd5, {divs[i], 1'b1});
        chk("R10 scl_div", {1'b0, scl_div}, {1'b0, divs[i]});
        chk("R10 ctl_en", {15'd0, ctl_en}, 16'h0001);
        rd(3'd5, rv); chk("R10 clock reg readback", rv, {divs[i], 1'b1});
      end
    end

    // R2 / R12 readback and policy outputs
    wr(3'd3, 16'h00FC);
    rd(3'd3, rv); chk("R2 control1 readback", rv, 16'h00F4);
    chk("R12 policy outputs", {12'd0, stall_en, match_irq_en, gcall_en, nack_next}, 16'h000F);
    wr(3'd4, 16'h00D2);
    rd(3'd4, rv); chk("R2 own address readback", rv, 16'h00D2);
    chk("R12 slave_en/own_addr", {8'd0, slave_en, own_addr}, 16'h00D2);
    wr(3'd6, 16'h005A);
    rd(3'd6, rv); chk("R2 control3 readback", rv, 16'h005A);
    rd(3'd7, rv); chk("R2 offset 7 reads zero", rv, 16'h0000);

    // R3 / R4 write-1-to-clear sweep over all masks
    wr(3'd3, 16'h0084);
    for (int m = 0; m < 256; m++) begin
      ev_slave_stop = 1; ev_bus_err = 1; ev_nack = 1; ev_start_done = 1;
      ev_own_match = 1; ev_tx_empty = 1; tick();
      wr(3'd1, m[15:0]);
      rd(3'd1, rv);
      chk("R3 R4 status after w1c mask", rv, 16'h00FC & ~(m[15:0] & 16'h00BC));
      chk("R9 irq with flags", {15'd0, irq}, 16'h0001);
      clear_flags();
      rd(3'd1, rv);
      chk("R4 status after clear", rv, 16'h0000);
    end

    // R3 master/xmit levels, no irq
    eng_master = 1; eng_xmit = 1;
    rd(3'd1, rv); chk("R3 master/xmit bits", rv, 16'h0003);
    chk("R9 levels no irq", {15'd0, irq}, 16'h0000);
    eng_master = 0; eng_xmit = 0;

    // R9 irq per flag and enable
    for (int ie = 0; ie < 2; ie++) begin
      wr(3'd3, ie ? 16'h0084 : 16'h0080);
      for (int f = 0; f < 6; f++) begin
        case (f)
          0: ev_slave_stop = 1;
          1: ev_tx_empty = 1;
          2: ev_bus_err = 1;
          3: ev_nack = 1;
          4: ev_start_done = 1;
          default: ev_gcall_match = 1;
        endcase
        tick();
        chk("R9 irq per flag", {15'd0, irq}, ie[15:0]);
        clear_flags();
        chk("R9 irq after clear", {15'd0, irq}, 16'h0000);
      end
    end

    // R6 stall
    ev_start_done = 1; tick();
    chk("R6 stall_hold set", {15'd0, stall_hold}, 16'h0001);
    wr(3'd1, 16'h0008);
    chk("R6 stall_hold cleared", {15'd0, stall_hold}, 16'h0000);
    wr(3'd3, 16'h0004);
    ev_start_done = 1; tick();
    rd(3'd1, rv); chk("R6 no stall when disabled", rv, 16'h0000);

    // R5 set beats clear in the same cycle
    ev_tx_empty = 1; acc_rd = 1; acc_addr = 3'd0; tick();
    rd(3'd1, rv); chk("R5 sdast set vs data read", rv, 16'h0040);
    rd(3'd0, rv);
    ev_bus_err = 1; wr(3'd1, 16'h0020);
    rd(3'd1, rv); chk("R5 ber set vs w1c", rv, 16'h0020);
    clear_flags();

    // R7 requests
    wr(3'd3, 16'h0005);
    chk("R7 start_req set", {15'd0, start_req}, 16'h0001);
    wr(3'd3, 16'h0004);
    rd(3'd3, rv); chk("R7 write 0 keeps start", rv, 16'h0005);
    start_ack = 1; tick();
    rd(3'd3, rv); chk("R7 start cleared by ack", rv, 16'h0004);
    wr(3'd3, 16'h0006);
    chk("R7 stop_req set", {15'd0, stop_req}, 16'h0001);
    start_ack = 1; wr(3'd3, 16'h0005);
    chk("R7 write beats ack", {14'd0, stop_req, start_req}, 16'h0003);
    stop_ack = 1; start_ack = 1; tick();
    chk("R7 both acked", {14'd0, stop_req, start_req}, 16'h0000);

    // R8 control/status
    eng_bus_busy = 1; eng_ctl_busy = 1;
    ev_own_match = 1; tick();
    rd(3'd2, rv); chk("R8 own match + busy", rv, 16'h0007);
    ev_gcall_match = 1; tick();
    rd(3'd2, rv); chk("R8 gcall replaces own", rv, 16'h000B);
    rd(3'd1, rv); chk("R8 new match flag", rv, 16'h0004);
    ev_slave_stop = 1; tick();
    rd(3'd2, rv); chk("R8 slave stop clears match", rv, 16'h0003);
    eng_bus_busy = 0; eng_ctl_busy = 0;
    clear_flags();

    // R11 data register
    acc_wr = 1; acc_addr = 3'd0; acc_wdata = 16'h00A5; tick();
    chk("R11 tx_load pulse", {15'd0, tx_load}, 16'h0001);
    chk("R11 tx_data", {8'd0, tx_data}, 16'h00A5);
    tick();
    chk("R11 tx_load one cycle", {15'd0, tx_load}, 16'h0000);
    rx_byte = 8'h3C; ev_rx_valid = 1; tick();
    rd(3'd1, rv); chk("R4 rx sets sdast", rv, 16'h0040);
    rd(3'd0, rv); chk("R11 rx byte readback", rv, 16'h003C);
    rd(3'd1, rv); chk("R4 data read clears sdast", rv, 16'h0000);

    // R10 soft reset clears flags and requests at once
    ev_bus_err = 1; ev_nack = 1; tick();
    wr(3'd3, 16'h0007);
    wr(3'd5, 16'h0078);
    rd(3'd1, rv); chk("R10 flags cleared on disable", rv, 16'h0000);
    chk("R10 requests cleared", {14'd0, stop_req, start_req}, 16'h0000);
    chk("R10 irq low after disable", {15'd0, irq}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule